// File: doc/BRIEF.md
# Out-of-Range Alert Responder

The block watches a small set of channel readings. Each channel has an upper and a lower 8-bit limit and an enable bit. When an enabled channel presents a valid sample that falls outside its window, a per-channel sticky flag is set and the active-low alert line goes low. The host answers the alert with the SMBus alert-response procedure. It reads from the alert response address. The block acknowledges and returns its own address byte, which is made of a fixed type nibble, three strap-selected bits and a trailing bit driven high.

Returning the address does not clear the alert. The host must then address the device directly (Start, then the device's own 7-bit address). Once the device acknowledges that, every flag is cleared and the alert line is released. Normal register traffic and arbitration among several alerting devices are handled elsewhere. The bus inputs are taken as already synchronised to `clk`. The block only pulls SDA low, through `sda_oe`.

Top module: `alert_resp_unit`

## Requirements
- R1: A channel whose enable bit and valid strobe are both 1, and whose value is strictly greater than its high limit or strictly less than its low limit, sets its flag at that clock edge. `alert_n` reads 0 from the next cycle onward.
- R2: A value equal to either limit, a sample on a channel whose enable bit is 0, or a value presented while its valid strobe is 0 leaves `alert_n` at 1.
- R3: A set flag is sticky. Later in-range samples do not release `alert_n`, and `alert_n` rises only in the cycle after an own-address acknowledge.
- R4: A read to address 0001100 (address byte 0x19) is acknowledged (SDA pulled low in the ninth clock) only while the alert is pending. With no alert pending, the ninth bit reads 1.
- R5: After acknowledging 0x19, the device shifts out MSB first the byte {1001, A2, A1, A0, 1}, where A2..A0 are `strap_addr[2:0]`.
- R6: With `strap_open` = 1, the three address bits in both the returned byte and the own-address match are 111, whatever `strap_addr` holds.
- R7: When the host leaves the returned byte unacknowledged and issues a Stop, `sda_oe` is 0 and `alert_n` is still 0.
- R8: A Start followed by the own address {1001, A2, A1, A0}, with either R/W value, is acknowledged and releases `alert_n`.
- R9: A channel still out of range after release sets the alert again on its next valid sample.
- R10: An address byte matching neither the alert response address nor the own address is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_value | input | NCH*VW | Packed channel readings, channel 0 in the low bits |
| ch_valid | input | NCH | Per-channel sample strobe |
| ch_enable | input | NCH | Per-channel monitoring enable |
| lim_hi | input | NCH*VW | Packed upper limits |
| lim_lo | input | NCH*VW | Packed lower limits |
| strap_addr | input | 3 | Address straps A2..A0 |
| strap_open | input | 1 | Unbiased-strap option selected with pins open |
| scl | input | 1 | Synchronised bus clock |
| sda | input | 1 | Synchronised bus data (line level) |
| alert_n | output | 1 | Active-low alert |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with NCH = 2 and VW = 8. At that size every one of the 256 readings on one channel can be swept against a fixed window, which covers both limit edges exactly, and each alert raised by the sweep is cleared over the bus. All eight strap codes are run through the full alert-response exchange, with and without the open-strap option, so every returned address byte and every own-address match is compared against a value computed in the bench.

// File: rtl/arp_pkg.sv
package arp_pkg;
  localparam logic [6:0] ARA_ADDR = 7'b0001100;
  localparam logic [3:0] DEV_TYPE = 4'b1001;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ADDR,
    BS_ACK,
    BS_TX,
    BS_TXACK,
    BS_SKIP
  } bus_st_t;
endpackage

// File: rtl/limit_bank.sv
module limit_bank #(
  parameter int NCH = 4,
  parameter int VW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*VW-1:0] ch_value,
  input  logic [NCH-1:0]    ch_valid,
  input  logic [NCH-1:0]    ch_enable,
  input  logic [NCH*VW-1:0] lim_hi,
  input  logic [NCH*VW-1:0] lim_lo,
  input  logic              clr,
  output logic              any_flag
);
  logic [NCH-1:0] hit;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] flag_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [VW-1:0] v, hi, lo;
    assign v  = ch_value[i*VW +: VW];
    assign hi = lim_hi[i*VW +: VW];
    assign lo = lim_lo[i*VW +: VW];
    assign hit[i] = ch_valid[i] & ch_enable[i] & ((v > hi) | (v < lo));
  end

  // a new hit wins over a clear in the same cycle
  always_comb begin
    flag_d = (flag_q & {NCH{~clr}}) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign any_flag = |flag_q;
endmodule

// File: rtl/bus_edge.sv
module bus_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/alert_bus_fsm.sv
module alert_bus_fsm
  import arp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       sda_in,
  input  logic       pending,
  input  logic [6:0] own_addr,
  input  logic [7:0] reply,
  output logic       sda_oe,
  output logic       clr_pulse,
  output logic       ara_ack
);
  bus_st_t    st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       ara_q, ara_d;
  logic       clr_d;
  logic       oe_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    ara_d = ara_q;
    clr_d = 1'b0;
    if (start_ev) begin
      st_d  = BS_ADDR;
      cnt_d = '0;
    end else if (stop_ev) begin
      st_d = BS_IDLE;
    end else begin
      unique case (st_q)
        BS_ADDR: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_in};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (sh_q[7:1] == ARA_ADDR && sh_q[0] && pending) begin
              st_d  = BS_ACK;
              ara_d = 1'b1;
            end else if (sh_q[7:1] == own_addr) begin
              st_d  = BS_ACK;
              ara_d = 1'b0;
              clr_d = 1'b1;
            end else begin
              st_d = BS_SKIP;
            end
          end
        end
        BS_ACK: begin
          if (scl_fall) begin
            if (ara_q) begin
              st_d  = BS_TX;
              sh_d  = reply;
              cnt_d = '0;
            end else begin
              st_d = BS_SKIP;
            end
          end
        end
        BS_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              st_d = BS_TXACK;
            end else begin
              sh_d  = {sh_q[6:0], 1'b1};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        BS_TXACK: begin
          if (scl_rise) st_d = BS_SKIP;
        end
        default: ;
      endcase
    end
    oe_d = (st_d == BS_ACK) | ((st_d == BS_TX) & ~sh_d[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= BS_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      ara_q     <= 1'b0;
      sda_oe    <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      ara_q     <= ara_d;
      sda_oe    <= oe_d;
      clr_pulse <= clr_d;
    end
  end

  assign ara_ack = (st_q == BS_ACK) & ara_q;
endmodule

// File: rtl/alert_resp_unit.sv
module alert_resp_unit
  import arp_pkg::*;
#(
  parameter int NCH = 4,
  parameter int VW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*VW-1:0] ch_value,
  input  logic [NCH-1:0]    ch_valid,
  input  logic [NCH-1:0]    ch_enable,
  input  logic [NCH*VW-1:0] lim_hi,
  input  logic [NCH*VW-1:0] lim_lo,
  input  logic [2:0]        strap_addr,
  input  logic              strap_open,
  input  logic              scl,
  input  logic              sda,
  output logic              alert_n,
  output logic              sda_oe
);
  logic       pending;
  logic       alert_clr;
  logic       ara_ack;
  logic       scl_rise, scl_fall, start_ev, stop_ev;
  logic [2:0] eff_addr;
  logic [6:0] own_addr;
  logic [7:0] reply;

  assign eff_addr = strap_open ? 3'b111 : strap_addr;
  assign own_addr = {DEV_TYPE, eff_addr};
  assign reply    = {DEV_TYPE, eff_addr, 1'b1};

  limit_bank #(.NCH(NCH), .VW(VW)) u_lim (
    .clk(clk), .rst_n(rst_n), .ch_value(ch_value), .ch_valid(ch_valid),
    .ch_enable(ch_enable), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .clr(alert_clr), .any_flag(pending)
  );

  bus_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  alert_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_in(sda),
    .pending(pending), .own_addr(own_addr), .reply(reply),
    .sda_oe(sda_oe), .clr_pulse(alert_clr), .ara_ack(ara_ack)
  );

  assign alert_n = ~pending;
endmodule

// File: rtl/alert_resp_unit_chk.sv
module alert_resp_unit_chk #(
  parameter int NCH = 4,
  parameter int VW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH*VW-1:0] ch_value,
  input logic [NCH-1:0]    ch_valid,
  input logic [NCH-1:0]    ch_enable,
  input logic [NCH*VW-1:0] lim_hi,
  input logic [NCH*VW-1:0] lim_lo,
  input logic              scl,
  input logic              sda,
  input logic              alert_n,
  input logic              sda_oe,
  input logic              alert_clr,
  input logic              ara_ack
);
  logic out_any;
  always_comb begin
    out_any = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_valid[i] && ch_enable[i] &&
          (ch_value[i*VW +: VW] > lim_hi[i*VW +: VW] ||
           ch_value[i*VW +: VW] < lim_lo[i*VW +: VW]))
        out_any = 1'b1;
    end
  end

  a_r1_alert_low: assert property (@(posedge clk) disable iff (!rst_n)
    out_any |=> !alert_n);

  a_r3_release_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_n) |-> $past(alert_clr));

  a_r4_ara_ack_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ara_ack |-> (!alert_n && sda_oe));

  a_r7_stop_frees_sda: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl) && sda && !$past(sda)) |=> !sda_oe);
endmodule

bind alert_resp_unit alert_resp_unit_chk #(.NCH(NCH), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_value(ch_value), .ch_valid(ch_valid),
  .ch_enable(ch_enable), .lim_hi(lim_hi), .lim_lo(lim_lo), .scl(scl),
  .sda(sda), .alert_n(alert_n), .sda_oe(sda_oe), .alert_clr(alert_clr),
  .ara_ack(ara_ack)
);

// File: tb/alert_resp_unit_bench.sv
module alert_resp_unit_bench;
  localparam int NCH = 2;
  localparam int VW  = 8;
  localparam logic [7:0] LO = 8'h40;
  localparam logic [7:0] HI = 8'hC0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [NCH*VW-1:0] ch_value, lim_hi, lim_lo;
  logic [NCH-1:0]    ch_valid, ch_enable;
  logic [2:0]        strap_addr;
  logic              strap_open;
  logic              scl, host_sda;
  logic              alert_n, sda_oe;
  wire               sda_bus = host_sda & ~sda_oe;

  int total = 0;
  int bad   = 0;

  alert_resp_unit #(.NCH(NCH), .VW(VW)) u_alert_resp_unit (
    .clk(clk), .rst_n(rst_n), .ch_value(ch_value), .ch_valid(ch_valid),
    .ch_enable(ch_enable), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .strap_addr(strap_addr), .strap_open(strap_open), .scl(scl),
    .sda(sda_bus), .alert_n(alert_n), .sda_oe(sda_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; scl = 1'b1; tick(3);
    host_sda = 1'b0; tick(3);
    scl = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(2);
    scl = 1'b1; tick(3);
    host_sda = 1'b1; tick(3);
  endtask

  task automatic put_bit(input logic b);
    host_sda = b; tick(2);
    scl = 1'b1; tick(3);
    scl = 1'b0; tick(1);
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; tick(2);
    scl = 1'b1; tick(1);
    b = sda_bus; tick(2);
    scl = 1'b0; tick(1);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic sample(input int ch, input logic [7:0] v);
    ch_value[ch*VW +: VW] = v;
    ch_valid[ch] = 1'b1; tick(1);
    ch_valid[ch] = 1'b0; tick(1);
  endtask

  function automatic logic [2:0] eff(input logic [2:0] s, input logic o);
    return o ? 3'b111 : s;
  endfunction

  task automatic own_clear(input string req);
    logic ack;
    bus_start();
    put_byte({4'b1001, eff(strap_addr, strap_open), 1'b0}, ack);
    check({req, " R8 own ack"}, ack, 1'b0);
    bus_stop();
    check({req, " R8 released"}, alert_n, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic ack, b;
    logic [7:0] got;
    rst_n = 1'b0; scl = 1'b1; host_sda = 1'b1;
    ch_value = '0; ch_valid = '0; ch_enable = '1;
    lim_hi = {NCH{HI}}; lim_lo = {NCH{LO}};
    ch_value[VW +: VW] = 8'h80;
    strap_addr = 3'b010; strap_open = 1'b0;
    tick(4); rst_n = 1'b1; tick(2);
    check("reset alert_n", alert_n, 1'b1);
    check("reset sda_oe", sda_oe, 1'b0);

    // R4: no alert pending, ARA is not acknowledged
    bus_start(); put_byte(8'h19, ack); bus_stop();
    check("R4 no ack idle", ack, 1'b1);
    // R10: foreign address
    bus_start(); put_byte(8'hA4, ack); bus_stop();
    check("R10 foreign nack", ack, 1'b1);

    // R1 R2: full sweep of channel 0
    for (int v = 0; v < 256; v++) begin
      logic exp_out;
      exp_out = (v > HI) || (v < LO);
      sample(0, v[7:0]); tick(1);
      check($sformatf("R1 R2 value %0h", v), alert_n, !exp_out);
      if (exp_out) own_clear("sweep");
    end

    // R2: disabled channel and low strobe
    ch_enable[1] = 1'b0;
    sample(1, 8'hFF); tick(1);
    check("R2 disabled", alert_n, 1'b1);
    ch_enable[1] = 1'b1;
    ch_value[VW +: VW] = 8'h00; tick(3);
    check("R2 no strobe", alert_n, 1'b1);

    // R3: sticky after return to range
    sample(1, 8'h10);
    sample(1, 8'h80); tick(2);
    check("R3 sticky", alert_n, 1'b0);
    own_clear("R3");

    // R5 R6 R7: alert response across all straps
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 8; s++) begin
        strap_addr = s[2:0]; strap_open = o[0];
        sample(0, 8'hF0);
        bus_start(); put_byte(8'h19, ack);
        check("R4 ara ack", ack, 1'b0);
        got = '0;
        for (int i = 0; i < 8; i++) begin
          get_bit(b); got = {got[6:0], b};
        end
        check(o ? "R6 reply open" : "R5 reply", got, {4'b1001, eff(s[2:0], o[0]), 1'b1});
        put_bit(1'b1);
        bus_stop();
        check("R7 sda free", sda_oe, 1'b0);
        check("R7 alert held", alert_n, 1'b0);
        own_clear("R6");
      end
    end

    // R9: still out of range after release
    strap_open = 1'b0; strap_addr = 3'b101;
    sample(0, 8'h05);
    own_clear("R9");
    tick(3);
    check("R9 quiet without sample", alert_n, 1'b1);
    sample(0, 8'h05); tick(1);
    check("R9 reassert", alert_n, 1'b0);
    // R8: read form of own address also clears
    bus_start(); put_byte({4'b1001, 3'b101, 1'b1}, ack); bus_stop();
    check("R8 read ack", ack, 1'b0);
    check("R8 read release", alert_n, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule